// File: doc/BRIEF.md
# Comparator-to-Output Lookup Mapper

This block turns a 4-bit comparator result into a 4-bit output pattern. The comparator bits form an index into a 16-entry table, and each entry holds the output pattern for that index. Software reads and writes the table through a simple register port, and each entry sits at its own byte address. At reset the table is filled with one of two default patterns: a straight copy of the index or its bitwise complement. An inversion input picks the pattern.

The block does not pass a new index to the outputs at once. Each change restarts a settling timer. The lookup result is registered onto the outputs only when that timer runs out, so the analog comparators have time to settle.

The four output pins are shared with a serial interface. In standalone mode the lookup result drives the pins. In programming mode the pins belong to the serial engine, and the lookup result is frozen inside the block.

Top module: `cmp_lut_mapper`

## Requirements
- R1: The index is `cmp_in` with bit 3 as the most significant bit. In standalone mode, when the timer expires, `pin_o[3:0]` takes the table entry for that index. Entry bit i drives pin i.
- R2: Entry k sits in bits [3:0] of address 0x25+k, for k = 0..15. A write with `reg_we` high stores `reg_wdata[3:0]` at the clock edge. `reg_rdata` is combinational and returns `{4'b0000, entry}` for the current `reg_addr`.
- R3: A write to any address outside 0x25..0x34 changes no entry. A read of such an address returns 0x00.
- R4: Reset is synchronous and active low. With `inv_sel`=0 during reset, entry k is loaded with k. With `inv_sel`=1, entry k is loaded with the complement of k, so entry 0 holds 0xF and entry 15 holds 0x0.
- R5: Changing `inv_sel` after reset leaves every entry as it is.
- R6: The settling delay is D = BASE_TICKS·2^`wait_code` cycles, which is 1 cycle for code 0 at the default base. Suppose a new index is sampled at clock edge E. The outputs then take the new entry at edge E+D, and `wait_code` is read at edge E.
- R7: If the index changes again before the timer expires, the count restarts from the newer change. The outputs keep their previous value until the timer expires.
- R8: A table write does not reach the outputs at once. The outputs show the value the entry holds when the next load happens.
- R9: After reset the lookup outputs are 0. The timer is armed as if index 0 had just arrived with a 1-cycle delay.
- R10: With `mode_sa`=1, `pin_oe` is all ones and `ser_i` is all zeros.
- R11: With `mode_sa`=0, `pin_o`=`ser_o`, `pin_oe`=`ser_oe` and `ser_i`=`pin_i`. The lookup value is held, and the timer restarts on every edge. After a return to standalone, the lookup loads D cycles after the last programming-mode edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmp_in | input | 4 | Comparator result bits, used as the table index |
| inv_sel | input | 1 | Selects the default table pattern loaded at reset |
| wait_code | input | 4 | Settling delay exponent |
| mode_sa | input | 1 | 1 = standalone, 0 = programming |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| ser_o | input | 4 | Serial engine pin drive values |
| ser_oe | input | 4 | Serial engine pin output enables |
| ser_i | output | 4 | Pin input values forwarded to the serial engine |
| pin_i | input | 4 | Pad input values |
| pin_o | output | 4 | Pad output values |
| pin_oe | output | 4 | Pad output enables |

## Verification
Pin, enable and read-data results are combinational from the current inputs and the table. They are due in the same cycle as the stimulus. Table writes appear on `reg_rdata` one edge after the write. An index first sampled at edge E shows on `pin_o` at edge E+D. A return to standalone loads D edges after the last programming edge.

The bench drives stimulus 3 ns after each rising edge and compares against its reference model 2 ns after each edge. Directed checks count exactly D cycles where the old value must still hold, then check the new value one tick later.

// File: rtl/cmp_lut_pkg.sv
package cmp_lut_pkg;

   // Who owns a shared pad.
   typedef enum logic {
      PIN_SERIAL = 1'b0,
      PIN_LOOKUP = 1'b1
   } pin_owner_e;

   // Width of the settling counter so it holds base << (2^code_w - 1).
   function automatic int cnt_width(input int base_ticks, input int code_w);
      return $clog2(base_ticks + 1) + (1 << code_w);
   endfunction

endpackage

// File: rtl/cmp_lut_bank.sv
module cmp_lut_bank #(
   parameter int IDX_W     = 4,
   parameter int OUT_W     = 4,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int BASE_ADDR = 'h25
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              inv_sel,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic [IDX_W-1:0]  sel_idx,
   output logic [OUT_W-1:0]  sel_val
);
   localparam int NUM_ENT = 1 << IDX_W;

   if (DATA_W < OUT_W) begin : g_bad_data
      $error("cmp_lut_bank: DATA_W must be at least OUT_W");
   end
   if (BASE_ADDR + NUM_ENT > (1 << ADDR_W)) begin : g_bad_addr
      $error("cmp_lut_bank: table does not fit the address space");
   end

   logic [OUT_W-1:0] ent_w [NUM_ENT];
   logic [ADDR_W:0]  off_full;
   logic             hit;
   logic [IDX_W-1:0] off_idx;

   assign off_full = {1'b0, addr} - (ADDR_W+1)'(BASE_ADDR);
   assign hit      = (off_full[ADDR_W] == 1'b0) && (off_full < (ADDR_W+1)'(NUM_ENT));
   assign off_idx  = off_full[IDX_W-1:0];

   for (genvar k = 0; k < NUM_ENT; k++) begin : g_ent
      logic [OUT_W-1:0] val_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            val_q <= inv_sel ? ~OUT_W'(k) : OUT_W'(k);
         end else if (wr_en && hit && (off_idx == IDX_W'(k))) begin
            val_q <= wdata[OUT_W-1:0];
         end
      end
      assign ent_w[k] = val_q;
   end

   assign rdata   = hit ? DATA_W'(ent_w[off_idx]) : '0;
   assign sel_val = ent_w[sel_idx];

endmodule

// File: rtl/cmp_lut_timer.sv
module cmp_lut_timer #(
   parameter int IDX_W      = 4,
   parameter int CODE_W     = 4,
   parameter int BASE_TICKS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [IDX_W-1:0]  idx_in,
   input  logic [CODE_W-1:0] code,
   output logic [IDX_W-1:0]  idx_q,
   output logic              load
);
   localparam int CNT_W = cmp_lut_pkg::cnt_width(BASE_TICKS, CODE_W);

   if (BASE_TICKS < 1) begin : g_bad_base
      $error("cmp_lut_timer: BASE_TICKS must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] span;
   logic             pend_q;
   logic             restart;

   assign span    = CNT_W'(BASE_TICKS) << code;
   assign restart = !run || (idx_in != idx_q);
   assign load    = !restart && pend_q && (cnt_q == CNT_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q  <= '0;
         cnt_q  <= CNT_W'(1);
         pend_q <= 1'b1;
      end else if (restart) begin
         idx_q  <= idx_in;
         cnt_q  <= span;
         pend_q <= 1'b1;
      end else if (load) begin
         pend_q <= 1'b0;
      end else if (pend_q) begin
         cnt_q  <= cnt_q - CNT_W'(1);
      end
   end

endmodule

// File: rtl/cmp_lut_pinmux.sv
module cmp_lut_pinmux #(
   parameter int   PIN_W    = 4,
   parameter logic SER_IDLE = 1'b0
) (
   input  logic             standalone,
   input  logic [PIN_W-1:0] lut_val,
   input  logic [PIN_W-1:0] ser_o,
   input  logic [PIN_W-1:0] ser_oe,
   input  logic [PIN_W-1:0] pin_i,
   output logic [PIN_W-1:0] pin_o,
   output logic [PIN_W-1:0] pin_oe,
   output logic [PIN_W-1:0] ser_i
);
   cmp_lut_pkg::pin_owner_e owner;
   assign owner = standalone ? cmp_lut_pkg::PIN_LOOKUP : cmp_lut_pkg::PIN_SERIAL;

   for (genvar p = 0; p < PIN_W; p++) begin : g_pin
      always_comb begin
         if (owner == cmp_lut_pkg::PIN_LOOKUP) begin
            pin_o[p]  = lut_val[p];
            pin_oe[p] = 1'b1;
            ser_i[p]  = SER_IDLE;
         end else begin
            pin_o[p]  = ser_o[p];
            pin_oe[p] = ser_oe[p];
            ser_i[p]  = pin_i[p];
         end
      end
   end

endmodule

// File: rtl/cmp_lut_mapper.sv
module cmp_lut_mapper #(
   parameter int IDX_W      = 4,
   parameter int OUT_W      = 4,
   parameter int DATA_W     = 8,
   parameter int ADDR_W     = 8,
   parameter int BASE_ADDR  = 'h25,
   parameter int CODE_W     = 4,
   parameter int BASE_TICKS = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [IDX_W-1:0]  cmp_in,
   input  logic              inv_sel,
   input  logic [CODE_W-1:0] wait_code,
   input  logic              mode_sa,
   input  logic              reg_we,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [OUT_W-1:0]  ser_o,
   input  logic [OUT_W-1:0]  ser_oe,
   output logic [OUT_W-1:0]  ser_i,
   input  logic [OUT_W-1:0]  pin_i,
   output logic [OUT_W-1:0]  pin_o,
   output logic [OUT_W-1:0]  pin_oe
);
   logic [IDX_W-1:0] idx_q;
   logic             load;
   logic [OUT_W-1:0] sel_val;
   logic [OUT_W-1:0] lut_q;

   cmp_lut_timer #(
      .IDX_W(IDX_W), .CODE_W(CODE_W), .BASE_TICKS(BASE_TICKS)
   ) u_timer (
      .clk(clk), .rst_n(rst_n), .run(mode_sa), .idx_in(cmp_in),
      .code(wait_code), .idx_q(idx_q), .load(load)
   );

   cmp_lut_bank #(
      .IDX_W(IDX_W), .OUT_W(OUT_W), .DATA_W(DATA_W),
      .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .inv_sel(inv_sel), .wr_en(reg_we),
      .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
      .sel_idx(idx_q), .sel_val(sel_val)
   );

   always_ff @(posedge clk) begin
      if (!rst_n)    lut_q <= '0;
      else if (load) lut_q <= sel_val;
   end

   cmp_lut_pinmux #(
      .PIN_W(OUT_W), .SER_IDLE(1'b0)
   ) u_pins (
      .standalone(mode_sa), .lut_val(lut_q), .ser_o(ser_o), .ser_oe(ser_oe),
      .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe), .ser_i(ser_i)
   );

endmodule

// File: rtl/cmp_lut_mapper_chk.sv
module cmp_lut_mapper_chk #(
   parameter int IDX_W     = 4,
   parameter int OUT_W     = 4,
   parameter int DATA_W    = 8,
   parameter int ADDR_W    = 8,
   parameter int BASE_ADDR = 'h25
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mode_sa,
   input logic [IDX_W-1:0]  cmp_in,
   input logic              reg_we,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] reg_rdata,
   input logic [OUT_W-1:0]  pin_oe,
   input logic [OUT_W-1:0]  lut_q
);
   localparam int NUM_ENT = 1 << IDX_W;

   logic warm_q;
   logic in_tab;

   always_ff @(posedge clk) begin
      if (!rst_n) warm_q <= 1'b0;
      else        warm_q <= 1'b1;
   end

   assign in_tab = (int'(reg_addr) >= BASE_ADDR) && (int'(reg_addr) < BASE_ADDR + NUM_ENT);

   // R10
   standalone_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_sa |-> (pin_oe == '1));

   // R3
   rdata_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[DATA_W-1:OUT_W] == '0);

   // R2
   write_readback_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we && in_tab) |=> ($stable(reg_addr) |-> (reg_rdata[OUT_W-1:0] == $past(reg_wdata[OUT_W-1:0]))));

   // R11
   hold_in_prog_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_sa |=> $stable(lut_q));

   // R7
   no_early_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (warm_q && mode_sa && (cmp_in != $past(cmp_in))) |=> $stable(lut_q));

endmodule

bind cmp_lut_mapper cmp_lut_mapper_chk #(
   .IDX_W(IDX_W), .OUT_W(OUT_W), .DATA_W(DATA_W),
   .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .mode_sa(mode_sa), .cmp_in(cmp_in),
   .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
   .reg_rdata(reg_rdata), .pin_oe(pin_oe), .lut_q(lut_q)
);

// File: tb/test_cmp_lut_mapper.sv
`timescale 1ns/1ps
module test_cmp_lut_mapper;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] cmp_in = '0;
   logic       inv_sel = 1'b1;
   logic [3:0] wait_code = '0;
   logic       mode_sa = 1'b1;
   logic       reg_we = 1'b0;
   logic [7:0] reg_addr = '0;
   logic [7:0] reg_wdata = '0;
   logic [7:0] reg_rdata;
   logic [3:0] ser_o = '0;
   logic [3:0] ser_oe = '0;
   logic [3:0] ser_i;
   logic [3:0] pin_i = '0;
   logic [3:0] pin_o;
   logic [3:0] pin_oe;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   bit done = 0;

   // reference model state
   int m_tab [16];
   int m_idx = 0;
   int m_due = -1;
   int m_out = 0;

   always #4 clk = ~clk;

   cmp_lut_mapper i_cmp_lut_mapper (
      .clk(clk), .rst_n(rst_n), .cmp_in(cmp_in), .inv_sel(inv_sel),
      .wait_code(wait_code), .mode_sa(mode_sa), .reg_we(reg_we),
      .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ser_o(ser_o), .ser_oe(ser_oe), .ser_i(ser_i), .pin_i(pin_i),
      .pin_o(pin_o), .pin_oe(pin_oe)
   );

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cyc, act, exp);
      end
   endtask

   // behavioural reference, updated at each rising edge
   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         for (int k = 0; k < 16; k++) m_tab[k] = inv_sel ? (15 - k) : k;
         m_out = 0;
         m_idx = 0;
         m_due = cyc + 1;
      end else begin
         if (!mode_sa || int'(cmp_in) != m_idx) begin
            m_idx = int'(cmp_in);
            m_due = cyc + (1 << wait_code);
         end else if (m_due == cyc) begin
            m_out = m_tab[m_idx];
            m_due = -1;
         end
         if (reg_we && reg_addr >= 8'h25 && reg_addr <= 8'h34)
            m_tab[reg_addr - 8'h25] = int'(reg_wdata[3:0]);
      end
   end

   // per-cycle comparison, 2 ns after the edge
   always @(posedge clk) begin
      #2;
      if (rst_n && !done) begin
         int exp_rd;
         exp_rd = (reg_addr >= 8'h25 && reg_addr <= 8'h34) ? m_tab[reg_addr - 8'h25] : 0;
         chk("R2/R3/R4/R5 rdata", int'(reg_rdata), exp_rd);
         if (mode_sa) begin
            chk("R1/R6/R7/R8/R9 pin_o", int'(pin_o), m_out);
            chk("R10 pin_oe", int'(pin_oe), 15);
            chk("R10 ser_i", int'(ser_i), 0);
         end else begin
            chk("R11 pin_o", int'(pin_o), int'(ser_o));
            chk("R11 pin_oe", int'(pin_oe), int'(ser_oe));
            chk("R11 ser_i", int'(ser_i), int'(pin_i));
         end
      end
   end

   task automatic tick(input int n = 1);
      repeat (n) begin
         @(posedge clk);
         #3;
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_we = 1'b1;
      tick();
      reg_we = 1'b0;
   endtask

   task automatic do_reset(input logic inv);
      inv_sel = inv; rst_n = 1'b0; cmp_in = '0; mode_sa = 1'b1; wait_code = '0;
      tick(3);
      rst_n = 1'b1;
      chk("R9 outputs zero after reset", int'(pin_o), 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin : stim
      // reset with complement defaults
      do_reset(1'b1);
      tick();
      chk("R9 entry 0 loaded one cycle after reset", int'(pin_o), 15);
      for (int k = 0; k < 16; k++) begin
         reg_addr = 8'(8'h25 + k);
         #1;
         chk("R4 complement default", int'(reg_rdata), 15 - k);
         tick();
      end
      // inversion change after reset
      inv_sel = 1'b0;
      tick(2);
      reg_addr = 8'h28;
      #1;
      chk("R5 entry unchanged after inv_sel flip", int'(reg_rdata), 12);
      tick();
      // out-of-range writes
      wr(8'h24, 8'hFF);
      wr(8'h35, 8'hFF);
      wr(8'h00, 8'hFF);
      reg_addr = 8'h24; #1;
      chk("R3 out-of-range read is zero", int'(reg_rdata), 0);
      reg_addr = 8'h25; #1;
      chk("R3 entry 0 untouched", int'(reg_rdata), 15);
      reg_addr = 8'h34; #1;
      chk("R3 entry 15 untouched", int'(reg_rdata), 0);
      tick();
      // write entry 5
      wr(8'h2A, 8'hA3);
      reg_addr = 8'h2A; #1;
      chk("R2 readback low nibble only", int'(reg_rdata), 3);
      tick();
      // settling delay with code 2 (4 cycles)
      wait_code = 4'd2;
      cmp_in = 4'd5;
      tick(4);
      chk("R6 old value before delay", int'(pin_o), 15);
      tick();
      chk("R6 new value at delay", int'(pin_o), 3);
      // restart on a second change, code 3 (8 cycles)
      wait_code = 4'd3;
      cmp_in = 4'd6;
      tick(3);
      cmp_in = 4'd7;
      tick(8);
      chk("R7 held through restarted count", int'(pin_o), 3);
      tick();
      chk("R7 new value after restarted count", int'(pin_o), 8);
      // write to the active entry
      wr(8'h2C, 8'h06);
      tick(10);
      chk("R8 write not visible without a load", int'(pin_o), 8);
      wait_code = 4'd0;
      cmp_in = 4'd0;
      tick(2);
      chk("R1 entry 0 via index 0", int'(pin_o), 15);
      cmp_in = 4'd7;
      tick(2);
      chk("R8 written value appears at next load", int'(pin_o), 6);
      // programming mode
      mode_sa = 1'b0; ser_o = 4'hA; ser_oe = 4'h5; pin_i = 4'h3; cmp_in = 4'd2;
      #1;
      chk("R11 pin_o from serial", int'(pin_o), 10);
      chk("R11 pin_oe from serial", int'(pin_oe), 5);
      chk("R11 ser_i from pads", int'(ser_i), 3);
      tick(5);
      mode_sa = 1'b1;
      #1;
      chk("R11 lookup held over programming mode", int'(pin_o), 6);
      tick();
      chk("R11 load after return to standalone", int'(pin_o), 13);
      // index sweep with 1-cycle delay
      for (int k = 0; k < 16; k++) begin
         cmp_in = 4'(k);
         tick(2);
      end
      // mixed random traffic
      for (int n = 0; n < 600; n++) begin
         cmp_in    = 4'($urandom_range(0, 15));
         wait_code = 4'($urandom_range(0, 2));
         if ($urandom_range(0, 15) == 0) mode_sa = ~mode_sa;
         ser_o  = 4'($urandom);
         ser_oe = 4'($urandom);
         pin_i  = 4'($urandom);
         reg_we = ($urandom_range(0, 3) == 0);
         reg_addr  = 8'($urandom_range(8'h20, 8'h37));
         reg_wdata = 8'($urandom);
         tick($urandom_range(1, 6));
      end
      reg_we = 1'b0;
      mode_sa = 1'b1;
      // reset with identity defaults
      do_reset(1'b0);
      tick();
      chk("R9 entry 0 after identity reset", int'(pin_o), 0);
      for (int k = 0; k < 16; k++) begin
         reg_addr = 8'(8'h25 + k);
         #1;
         chk("R4 identity default", int'(reg_rdata), k);
         tick();
      end
      cmp_in = 4'd9;
      tick(2);
      chk("R1 identity lookup of index 9", int'(pin_o), 9);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule